// File: doc/BRIEF.md
# DCC Byte Inserter

This block feeds the data-communication-channel bytes of the transmit section overhead into an outgoing frame. A host loads a bank of 72 eight-bit bytes as 36 sixteen-bit words. Three of those bytes go into every frame, one in each of the D1, D2 and D3 overhead slots, so the bank covers 24 consecutive frames and then starts over. Byte order runs through each word from the high half to the low half, then on to the next word. Frame boundaries therefore fall in the middle of a word, and the block unpacks the bytes one at a time.

The frame generator around the block supplies a frame-start pulse and one strobe for each of the three slots. The inserter answers in the same cycle with the byte for that slot and a valid flag. A running byte index moves forward on every slot strobe. A frame-start pulse arriving in the middle of a triple pushes the index on to the next frame's D1, so a missed strobe costs at most one frame of misalignment. Host writes go straight into the bank, with no shadow copy. A write aimed at the word being read in that same cycle is forwarded to the output.

Top module: `dcc_tx_inserter`

## Requirements
- R1: A synchronous active-high reset clears all 36 bank words to zero and sets the byte index to 0, so the first slot strobe after reset returns 0x00.
- R2: `dccValid` is high exactly in cycles where at least one slot strobe is high, and `dccByte` is 0x00 whenever `dccValid` is low.
- R3: Byte index k (0..71) is the byte for frame k/3+1 and slot k%3 (0=D1, 1=D2, 2=D3). It is read from bank word k/2: bits [15:8] when k is even, bits [7:0] when k is odd.
- R4: Each cycle with a slot strobe returns the byte at the current index and then advances the index by one. After index 71 the index returns to 0. With no strobe and no frame-start pulse the index holds its value.
- R5: Several slot strobes high in the same cycle count as a single slot: one byte is returned and the index advances by one.
- R6: A frame-start pulse while the index is not a multiple of 3 moves the index up to the next multiple of 3, and 72 becomes 0. A pulse while the index is already a multiple of 3 leaves it unchanged. A pulse with no strobe produces no output.
- R7: When a frame-start pulse and a slot strobe share a cycle, the alignment of R6 is applied first. The strobe returns the byte at the aligned index, and the index then advances by one from there.
- R8: A host write with address 0..35 replaces that bank word from the next cycle on, and every later read of the word returns the new value.
- R9: A host write to the word that a slot strobe reads in the same cycle is forwarded, so the output byte comes from the newly written data.
- R10: A host write with address 36..63 changes no bank word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostWrEn | input | 1 | Host write enable for one bank word |
| hostWrAddr | input | 6 | Bank word address; 0..35 valid |
| hostWrData | input | 16 | Word data, earlier byte in [15:8] |
| frameStart | input | 1 | Pulse marking the start of a frame |
| slotD1 | input | 1 | D1 slot strobe |
| slotD2 | input | 1 | D2 slot strobe |
| slotD3 | input | 1 | D3 slot strobe |
| dccByte | output | 8 | Byte to insert in the current slot |
| dccValid | output | 1 | High in a cycle with a slot strobe |

## Verification
Two functions can fall in the same cycle. The first is a host write landing on the word that the current slot strobe reads. The stimulus provokes it by writing that word while strobing the odd byte whose high half was just consumed, and the result is judged against the newly written low byte, not the old one. The second is a frame-start pulse meeting a slot strobe while the index is misaligned. The stimulus drops strobes so the index sits mid-triple, and the result is judged by the byte at the next multiple of 3 followed by the byte just after it. A scoreboard model that applies the write first and the alignment first predicts each expected byte.

// File: rtl/dcc_ins_pkg.sv
package dcc_ins_pkg;

  // Default geometry of the transmit channel bank
  localparam int DCC_FRAMES_DEF = 24;  // frames in one cycle of the bank
  localparam int DCC_SLOTS      = 3;   // D-byte slots in one frame
  localparam int DCC_BYTE_W_DEF = 8;

  // Read command from sequencer to bank: the strobes the datapath needs
  typedef struct packed {
    logic rdEn;     // a slot is being served this cycle
    logic rdLower;  // take the low half of the addressed word
  } dccRdCmd_t;

endpackage

// File: rtl/dcc_seq_ctrl.sv
module dcc_seq_ctrl
  import dcc_ins_pkg::*;
#(
  parameter int FRAMES = DCC_FRAMES_DEF,
  parameter int SLOTS  = DCC_SLOTS,
  localparam int NBYTES  = FRAMES * SLOTS,
  localparam int NWORDS  = NBYTES / 2,
  localparam int IDX_W   = $clog2(NBYTES),
  localparam int WADDR_W = $clog2(NWORDS),
  localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frameStart,
  input  logic [SLOTS-1:0]   slotStb,
  output dccRdCmd_t          rdCmd,
  output logic [WADDR_W-1:0] rdWord
);

  logic [IDX_W-1:0]  byteIdx;
  logic [SLOT_W-1:0] slotPos;   // byteIdx modulo SLOTS, kept alongside

  logic              anyStb;
  logic              misaligned;
  logic              doAlign;
  logic [IDX_W:0]    alignSum;
  logic [IDX_W-1:0]  alignedIdx;
  logic [IDX_W-1:0]  effIdx;
  logic [SLOT_W-1:0] effSlot;
  logic [IDX_W-1:0]  nxtIdx;
  logic [SLOT_W-1:0] nxtSlot;

  assign anyStb     = |slotStb;
  assign misaligned = (slotPos != '0);
  assign doAlign    = frameStart && misaligned;

  // Distance to the next frame boundary, wrapping at the end of the bank
  always_comb begin
    alignSum = {1'b0, byteIdx} + (IDX_W+1)'(SLOTS) - (IDX_W+1)'(slotPos);
    if (alignSum >= (IDX_W+1)'(NBYTES)) begin
      alignedIdx = '0;
    end else begin
      alignedIdx = alignSum[IDX_W-1:0];
    end
  end

  // Alignment takes effect before the strobe of the same cycle
  assign effIdx  = doAlign ? alignedIdx : byteIdx;
  assign effSlot = doAlign ? '0 : slotPos;

  always_comb begin
    nxtIdx  = effIdx;
    nxtSlot = effSlot;
    if (anyStb) begin
      nxtIdx  = (effIdx == IDX_W'(NBYTES-1)) ? '0 : effIdx + 1'b1;
      nxtSlot = (effSlot == SLOT_W'(SLOTS-1)) ? '0 : effSlot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byteIdx <= '0;
      slotPos <= '0;
    end else begin
      byteIdx <= nxtIdx;
      slotPos <= nxtSlot;
    end
  end

  assign rdCmd.rdEn    = anyStb;
  assign rdCmd.rdLower = effIdx[0];
  assign rdWord        = effIdx[IDX_W-1:1];

  // Index stays inside the bank
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    byteIdx < IDX_W'(NBYTES)) else $error("index out of range"); // R4

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (anyStb && !frameStart && byteIdx == IDX_W'(NBYTES-1)) |=> (byteIdx == '0))
    else $error("no wrap after last byte"); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (anyStb && !frameStart && byteIdx != IDX_W'(NBYTES-1))
      |=> (byteIdx == $past(byteIdx) + 1'b1))
    else $error("strobe did not advance by one"); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!anyStb && !frameStart) |=> $stable(byteIdx))
    else $error("index moved while idle"); // R4

  AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (frameStart && !anyStb) |=> (slotPos == '0))
    else $error("frame start left index misaligned"); // R6

  AST_FRAME_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    (frameStart && anyStb) |=> (slotPos == SLOT_W'(1)))
    else $error("frame start plus strobe not served at D1"); // R7

  AST_RESET_INDEX: assert property (@(posedge clk)
    rst |=> (byteIdx == '0)) else $error("reset did not clear index"); // R1

endmodule

// File: rtl/dcc_bank_dp.sv
module dcc_bank_dp
  import dcc_ins_pkg::*;
#(
  parameter int BYTE_W      = DCC_BYTE_W_DEF,
  parameter int NWORDS      = 36,
  parameter int HOST_ADDR_W = 6,
  localparam int WORD_W  = 2 * BYTE_W,
  localparam int WADDR_W = $clog2(NWORDS),
  localparam int FLAT_W  = NWORDS * WORD_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic [HOST_ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0]      wrData,
  input  dccRdCmd_t              rdCmd,
  input  logic [WADDR_W-1:0]     rdWord,
  output logic [BYTE_W-1:0]      dccByte,
  output logic                   dccValid
);

  logic [WORD_W-1:0] bankWords [NWORDS];
  logic [FLAT_W-1:0] bankFlat;
  logic              wrInRange;
  logic              wrHitsRead;
  logic [WORD_W-1:0] srcWord;
  logic [BYTE_W-1:0] pickByte;

  assign wrInRange = wrEn && (32'(wrAddr) < NWORDS);

  // One storage word per bank entry, each with its own address decode
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        wordQ <= '0;
      end else if (wrInRange && (32'(wrAddr) == w)) begin
        wordQ <= wrData;
      end
    end
    assign bankWords[w]                     = wordQ;
    assign bankFlat[w*WORD_W +: WORD_W]     = wordQ;
  end

  // Same-cycle write to the word being read is forwarded
  assign wrHitsRead = wrInRange && (wrAddr == HOST_ADDR_W'(rdWord));
  assign srcWord    = wrHitsRead ? wrData : bankWords[rdWord];
  assign pickByte   = rdCmd.rdLower ? srcWord[BYTE_W-1:0]
                                    : srcWord[WORD_W-1 -: BYTE_W];

  assign dccByte  = rdCmd.rdEn ? pickByte : '0;
  assign dccValid = rdCmd.rdEn;

  AST_RESET_CLEARS_BANK: assert property (@(posedge clk)
    rst |=> (bankFlat == '0)) else $error("bank not cleared by reset"); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && 32'(wrAddr) < NWORDS) |=> (bankWords[$past(wrAddr)] == $past(wrData)))
    else $error("host write did not land"); // R8

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wrEn && 32'(wrAddr) >= NWORDS) |=> $stable(bankFlat))
    else $error("out-of-range write changed the bank"); // R10

  AST_FORWARD_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (rdCmd.rdEn && wrEn && wrAddr == HOST_ADDR_W'(rdWord) && !rdCmd.rdLower)
      |=> (bankWords[$past(rdWord)][WORD_W-1 -: BYTE_W] == $past(dccByte)))
    else $error("forwarded byte differs from stored byte"); // R9

endmodule

// File: rtl/dcc_tx_inserter.sv
module dcc_tx_inserter
  import dcc_ins_pkg::*;
#(
  parameter int FRAMES      = DCC_FRAMES_DEF,
  parameter int BYTE_W      = DCC_BYTE_W_DEF,
  parameter int HOST_ADDR_W = 6,
  localparam int NBYTES  = FRAMES * DCC_SLOTS,
  localparam int NWORDS  = NBYTES / 2,
  localparam int WADDR_W = $clog2(NWORDS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hostWrEn,
  input  logic [HOST_ADDR_W-1:0] hostWrAddr,
  input  logic [2*BYTE_W-1:0]    hostWrData,
  input  logic                   frameStart,
  input  logic                   slotD1,
  input  logic                   slotD2,
  input  logic                   slotD3,
  output logic [BYTE_W-1:0]      dccByte,
  output logic                   dccValid
);

  dccRdCmd_t          rdCmd;
  logic [WADDR_W-1:0] rdWord;
  logic [DCC_SLOTS-1:0] slotStb;

  assign slotStb = {slotD3, slotD2, slotD1};

  dcc_seq_ctrl #(
    .FRAMES (FRAMES),
    .SLOTS  (DCC_SLOTS)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frameStart (frameStart),
    .slotStb    (slotStb),
    .rdCmd      (rdCmd),
    .rdWord     (rdWord)
  );

  dcc_bank_dp #(
    .BYTE_W      (BYTE_W),
    .NWORDS      (NWORDS),
    .HOST_ADDR_W (HOST_ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (hostWrEn),
    .wrAddr   (hostWrAddr),
    .wrData   (hostWrData),
    .rdCmd    (rdCmd),
    .rdWord   (rdWord),
    .dccByte  (dccByte),
    .dccValid (dccValid)
  );

  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    dccValid == (slotD1 || slotD2 || slotD3)) else $error("valid without strobe"); // R2

  AST_QUIET_BYTE: assert property (@(posedge clk) disable iff (rst)
    !dccValid |-> (dccByte == '0)) else $error("byte nonzero while not valid"); // R2

endmodule

// File: tb/dcc_tx_inserter_bench.sv
`timescale 1ns/1ps
module dcc_tx_inserter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostWrEn = 1'b0;
  logic [5:0]  hostWrAddr = '0;
  logic [15:0] hostWrData = '0;
  logic        frameStart = 1'b0;
  logic        slotD1 = 1'b0;
  logic        slotD2 = 1'b0;
  logic        slotD3 = 1'b0;
  logic [7:0]  dccByte;
  logic        dccValid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] mBank [36];
  int          mIdx = 0;
  logic [7:0]  expQ [$];
  string       tagQ [$];

  always #5 clk = ~clk;

  dcc_tx_inserter u_dcc_tx_inserter (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr),
    .hostWrData(hostWrData), .frameStart(frameStart), .slotD1(slotD1),
    .slotD2(slotD2), .slotD3(slotD3), .dccByte(dccByte), .dccValid(dccValid)
  );

  function automatic logic [7:0] patByte(input int k);
    return 8'((k * 37 + 11) % 256);
  endfunction

  // Driver: one cycle of stimulus; model applies write first, then alignment
  task automatic step(input bit wr, input int addr, input logic [15:0] data,
                      input bit fs, input bit d1, input bit d2, input bit d3,
                      input string tag);
    int eff;
    @(negedge clk);
    hostWrEn = wr; hostWrAddr = 6'(addr); hostWrData = data;
    frameStart = fs; slotD1 = d1; slotD2 = d2; slotD3 = d3;
    if (wr && addr < 36) mBank[addr] = data;
    eff = mIdx;
    if (fs && (eff % 3) != 0) eff = eff + 3 - (eff % 3);
    if (eff >= 72) eff = 0;
    if (d1 || d2 || d3) begin
      expQ.push_back((eff % 2 == 0) ? mBank[eff/2][15:8] : mBank[eff/2][7:0]);
      tagQ.push_back(tag);
      mIdx = (eff + 1) % 72;
    end else begin
      mIdx = eff;
    end
  endtask

  task automatic idle();
    step(0, 0, 16'h0, 0, 0, 0, 0, "R2");
  endtask

  task automatic strobe(input string tag);
    step(0, 0, 16'h0, 0, 1, 0, 0, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; hostWrEn = 0; frameStart = 0; slotD1 = 0; slotD2 = 0; slotD3 = 0;
    for (int w = 0; w < 36; w++) mBank[w] = 16'h0;
    mIdx = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: compares the design against the queue every cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst) begin
        checks++;
        if (dccValid) begin
          if (expQ.size() == 0) begin
            errors++;
            $display("FAIL R2: valid with no expected byte, actual %02h expected none", dccByte);
          end else begin
            logic [7:0] e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            if (dccByte !== e) begin
              errors++;
              $display("FAIL %s: byte actual %02h expected %02h", t, dccByte, e);
            end
          end
        end else begin
          if (expQ.size() != 0) begin
            string t;
            void'(expQ.pop_front());
            t = tagQ.pop_front();
            errors++;
            $display("FAIL %s: valid actual 0 expected 1", t);
          end else if (dccByte !== 8'h00) begin
            errors++;
            $display("FAIL R2: idle byte actual %02h expected 00", dccByte);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 36; w++) mBank[w] = 16'h0;
    doReset();
    idle();
    // R1: bank cleared after reset
    strobe("R1"); strobe("R1");
    doReset();

    // R8: load the whole bank
    for (int w = 0; w < 36; w++)
      step(1, w, {patByte(2*w), patByte(2*w+1)}, 0, 0, 0, 0, "R8");

    // R3: walk all 24 frames
    for (int f = 0; f < 24; f++) begin
      step(0, 0, 16'h0, 1, 0, 0, 0, "R6");
      step(0, 0, 16'h0, 0, 1, 0, 0, "R3");
      step(0, 0, 16'h0, 0, 0, 1, 0, "R3");
      step(0, 0, 16'h0, 0, 0, 0, 1, "R3");
    end
    // R4: after the 24th frame the sequence starts again
    step(0, 0, 16'h0, 1, 0, 0, 0, "R4");
    strobe("R4"); strobe("R4"); strobe("R4");

    // R5: two strobes at once count once (index 3)
    step(0, 0, 16'h0, 0, 1, 1, 0, "R5");
    strobe("R5");
    // R6: index 5 misaligned -> 6; then aligned pulse has no effect
    step(0, 0, 16'h0, 1, 0, 0, 0, "R6");
    strobe("R6");
    step(0, 0, 16'h0, 1, 0, 0, 0, "R6");
    step(0, 0, 16'h0, 1, 0, 0, 0, "R6");
    strobe("R6");
    // R7: index 10, pulse and strobe together -> byte 12, then 13
    step(0, 0, 16'h0, 1, 0, 1, 0, "R7");
    strobe("R7");
    // R8: index 14 reads high half of word 7 after a rewrite
    step(1, 7, 16'hC35A, 0, 0, 0, 0, "R8");
    strobe("R8");
    // R9: write word 7 while index 15 reads its low half
    step(1, 7, 16'h9E71, 0, 0, 0, 1, "R9");
    idle();
    // R10: out-of-range writes, then read the entire bank
    step(1, 36, 16'hFFFF, 0, 0, 0, 0, "R10");
    step(1, 50, 16'h1234, 0, 0, 0, 0, "R10");
    step(1, 63, 16'hABCD, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 72; i++) strobe("R10");
    // R6 wrap: move index 16 up to 70, pulse wraps to 0
    for (int i = 0; i < 54; i++) strobe("R4");
    step(0, 0, 16'h0, 1, 0, 0, 0, "R6");
    strobe("R6");
    // R1: reset mid-run clears bank and index
    doReset();
    strobe("R1"); strobe("R1");
    idle(); idle();

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: pending bytes actual %0d expected 0", expQ.size());
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule